// File: doc/BRIEF.md
# Pipeline Hazard and Operand Bypass Controller

This block watches the register fields of a five-stage in-order pipeline (fetch, decode, execute, memory, write-back) for an 8-bit processor with sixteen general registers and fixed 16-bit instructions. It produces four bypass selects. Two feed the execute-stage ALU operands. Two feed the decode stage, because the branch compare and target are evaluated there. It also raises one hold signal for the program counter and the fetch/decode register, a bubble request for the decode/execute register, and a flush of the fetch/decode slot when a branch is taken. All outputs are combinational in the current contents of the pipeline registers. The datapath samples them at its next clock edge.

Each cycle the controller classifies the situation into one of four named decisions, evaluated in priority order:

- `DEC_LOAD_USE`: the load in execute writes a register that the decode instruction reads.
- `DEC_BR_WAIT`: a branch in decode needs a value that execute or a memory-stage load has not yet produced.
- `DEC_FLUSH`: a branch in decode is taken with its operands ready.
- `DEC_RUN`: none of the above.

Holding in decode re-evaluates the same decision on the next cycle. Because of that, a branch behind a load waits through `DEC_LOAD_USE` and then `DEC_BR_WAIT` before it can reach `DEC_FLUSH` or `DEC_RUN`.

Top module: `hz_unit`

## Requirements
- R1: An execute operand select reads 01 when the memory-stage destination equals that source and its write enable is 1. It reads 10 when only the write-back destination matches with its write enable at 1. Otherwise it reads 00, meaning register file or pipeline register.
- R2: When both the memory and write-back destinations match one source with both write enables high, the select is 01 (the memory stage wins). This applies to execute and decode selects alike.
- R3: A stage whose write enable is 0 never causes a forward, even when its destination matches. Out of reset, with all enables low, every select is 00 and the hold, bubble and flush outputs are 0.
- R4: A load-use hazard raises front_hold=1 and idex_bubble=1 for that cycle. It exists when the execute stage holds a load with write enable 1 whose destination equals a decode source that is flagged as used.
- R5: A decode source whose use flag is 0 causes no stall. A non-load producer in execute causes no stall for a non-branch decode instruction.
- R6: Decode operand selects use the same 00/01/10 coding. A matching memory-stage load yields 00, not 01, for a decode select, because the loaded data is not ready there.
- R7: A branch in decode that reads a used source written by any execute-stage instruction with write enable 1 raises front_hold=1 and idex_bubble=1.
- R8: A branch in decode that reads a used source written by a memory-stage load with write enable 1 raises front_hold=1 and idex_bubble=1.
- R9: A branch in decode with id_br_taken=1 and no stall raises ifid_flush=1 with front_hold=0 and idex_bubble=0. A branch with id_br_taken=0 raises no flush.
- R10: While front_hold=1, ifid_flush is 0 even if the branch reports taken.
- R11: id_br_taken is ignored (ifid_flush=0) when id_is_branch is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| id_rs_a | input | 4 | Decode source A register |
| id_rs_b | input | 4 | Decode source B register |
| id_use_a | input | 1 | Decode instruction reads source A |
| id_use_b | input | 1 | Decode instruction reads source B |
| id_is_branch | input | 1 | Decode instruction is a conditional branch |
| id_br_taken | input | 1 | Branch outcome computed in decode |
| ex_rs_a | input | 4 | Execute source A register |
| ex_rs_b | input | 4 | Execute source B register |
| ex_rd | input | 4 | Execute destination register |
| ex_we | input | 1 | Execute register write enable |
| ex_is_load | input | 1 | Execute instruction is a load |
| mem_rd | input | 4 | Memory-stage destination |
| mem_we | input | 1 | Memory-stage write enable |
| mem_is_load | input | 1 | Memory-stage instruction is a load |
| wb_rd | input | 4 | Write-back destination |
| wb_we | input | 1 | Write-back write enable |
| fwd_ex_a | output | 2 | Execute operand A bypass select |
| fwd_ex_b | output | 2 | Execute operand B bypass select |
| fwd_id_a | output | 2 | Decode operand A bypass select |
| fwd_id_b | output | 2 | Decode operand B bypass select |
| front_hold | output | 1 | Hold PC and fetch/decode register |
| idex_bubble | output | 1 | Load a no-op with all write enables cleared into decode/execute |
| ifid_flush | output | 1 | Replace the fetch/decode instruction with a no-op |

## Verification
The two functions that can coincide are the stall and the taken-branch flush. They collide when a taken branch sits in decode behind a load or an ALU result it depends on. The bench builds exactly that pattern: id_br_taken is 1 while the execute stage holds the producer. It expects hold and bubble to be high with the flush low. A following vector with the producer gone must then show the flush alone. Bypass priority is provoked the same way, by aiming the memory and write-back destinations at one source in the same cycle.

// File: rtl/hz_pkg.sv
package hz_pkg;

    typedef enum logic [1:0] {
        FWD_RF  = 2'b00,
        FWD_MEM = 2'b01,
        FWD_WB  = 2'b10
    } fwd_sel_e;

    typedef enum logic [1:0] {
        DEC_RUN      = 2'b00,
        DEC_LOAD_USE = 2'b01,
        DEC_BR_WAIT  = 2'b10,
        DEC_FLUSH    = 2'b11
    } hz_dec_e;

endpackage

// File: rtl/hz_fwd_sel.sv
module hz_fwd_sel #(
    parameter int REG_W       = 4,
    parameter bit MEM_LOAD_OK = 1'b1
) (
    input  logic [REG_W-1:0] src_i,
    input  logic [REG_W-1:0] mem_rd_i,
    input  logic             mem_we_i,
    input  logic             mem_is_load_i,
    input  logic [REG_W-1:0] wb_rd_i,
    input  logic             wb_we_i,
    output hz_pkg::fwd_sel_e sel_o
);
    import hz_pkg::*;

    logic mem_hit;
    logic wb_hit;

    always_comb begin
        mem_hit = mem_we_i && (mem_rd_i == src_i);
        wb_hit  = wb_we_i && (wb_rd_i == src_i);
        if (mem_hit) begin
            // the younger producer shadows write-back even when its data is late
            sel_o = (MEM_LOAD_OK || !mem_is_load_i) ? FWD_MEM : FWD_RF;
        end else if (wb_hit) begin
            sel_o = FWD_WB;
        end else begin
            sel_o = FWD_RF;
        end
    end

    always_comb begin
        if (sel_o == FWD_WB) begin
            a_r2_mem_shadows_wb: assert (!(mem_we_i && (mem_rd_i == src_i)));
        end
        if (!mem_we_i && !wb_we_i) begin
            a_r3_idle_no_bypass: assert (sel_o == FWD_RF);
        end
    end

endmodule

// File: rtl/hz_stall_detect.sv
module hz_stall_detect #(
    parameter int REG_W   = 4,
    parameter int NUM_SRC = 2
) (
    input  logic [REG_W-1:0]   id_src_i [NUM_SRC],
    input  logic [NUM_SRC-1:0] id_use_i,
    input  logic               id_is_branch_i,
    input  logic [REG_W-1:0]   ex_rd_i,
    input  logic               ex_we_i,
    input  logic               ex_is_load_i,
    input  logic [REG_W-1:0]   mem_rd_i,
    input  logic               mem_we_i,
    input  logic               mem_is_load_i,
    output logic               load_use_o,
    output logic               br_wait_o
);

    logic [NUM_SRC-1:0] ex_hit;
    logic [NUM_SRC-1:0] mem_load_hit;

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
        assign ex_hit[g]       = id_use_i[g] && ex_we_i && (ex_rd_i == id_src_i[g]);
        assign mem_load_hit[g] = id_use_i[g] && mem_we_i && mem_is_load_i
                                 && (mem_rd_i == id_src_i[g]);
    end

    assign load_use_o = ex_is_load_i && (|ex_hit);
    assign br_wait_o  = id_is_branch_i && ((|ex_hit) || (|mem_load_hit));

    always_comb begin
        if (id_use_i == '0) begin
            a_r5_unused_no_stall: assert (!load_use_o && !br_wait_o);
        end
    end

endmodule

// File: rtl/hz_ctrl.sv
module hz_ctrl (
    input  logic load_use_i,
    input  logic br_wait_i,
    input  logic is_branch_i,
    input  logic br_taken_i,
    output logic hold_o,
    output logic bubble_o,
    output logic flush_o
);
    import hz_pkg::*;

    hz_dec_e dec;

    always_comb begin
        if (load_use_i) begin
            dec = DEC_LOAD_USE;
        end else if (br_wait_i) begin
            dec = DEC_BR_WAIT;
        end else if (is_branch_i && br_taken_i) begin
            dec = DEC_FLUSH;
        end else begin
            dec = DEC_RUN;
        end
    end

    always_comb begin
        unique case (dec)
            DEC_LOAD_USE, DEC_BR_WAIT: begin
                hold_o   = 1'b1;
                bubble_o = 1'b1;
                flush_o  = 1'b0;
            end
            DEC_FLUSH: begin
                hold_o   = 1'b0;
                bubble_o = 1'b0;
                flush_o  = 1'b1;
            end
            default: begin
                hold_o   = 1'b0;
                bubble_o = 1'b0;
                flush_o  = 1'b0;
            end
        endcase
    end

    always_comb begin
        a_r10_flush_excl_hold: assert (!(flush_o && hold_o));
        if (load_use_i || br_wait_i) begin
            a_r4_stall_gives_bubble: assert (hold_o && bubble_o);
        end
    end

endmodule

// File: rtl/hz_unit.sv
module hz_unit #(
    parameter int REG_W = 4
) (
    input  logic [REG_W-1:0] id_rs_a,
    input  logic [REG_W-1:0] id_rs_b,
    input  logic             id_use_a,
    input  logic             id_use_b,
    input  logic             id_is_branch,
    input  logic             id_br_taken,
    input  logic [REG_W-1:0] ex_rs_a,
    input  logic [REG_W-1:0] ex_rs_b,
    input  logic [REG_W-1:0] ex_rd,
    input  logic             ex_we,
    input  logic             ex_is_load,
    input  logic [REG_W-1:0] mem_rd,
    input  logic             mem_we,
    input  logic             mem_is_load,
    input  logic [REG_W-1:0] wb_rd,
    input  logic             wb_we,
    output logic [1:0]       fwd_ex_a,
    output logic [1:0]       fwd_ex_b,
    output logic [1:0]       fwd_id_a,
    output logic [1:0]       fwd_id_b,
    output logic             front_hold,
    output logic             idex_bubble,
    output logic             ifid_flush
);
    import hz_pkg::*;

    localparam int NUM_SRC = 2;
    localparam int NUM_OPS = 2 * NUM_SRC;

    logic [REG_W-1:0] op_src [NUM_OPS];
    fwd_sel_e         op_sel [NUM_OPS];
    logic [REG_W-1:0] id_src [NUM_SRC];
    logic             load_use;
    logic             br_wait;

    assign op_src[0] = ex_rs_a;
    assign op_src[1] = ex_rs_b;
    assign op_src[2] = id_rs_a;
    assign op_src[3] = id_rs_b;
    assign id_src[0] = id_rs_a;
    assign id_src[1] = id_rs_b;

    // execute operands may take a memory-stage load; decode operands may not
    for (genvar g = 0; g < NUM_OPS; g++) begin : g_op
        hz_fwd_sel #(
            .REG_W       (REG_W),
            .MEM_LOAD_OK (g < NUM_SRC)
        ) u_sel (
            .src_i         (op_src[g]),
            .mem_rd_i      (mem_rd),
            .mem_we_i      (mem_we),
            .mem_is_load_i (mem_is_load),
            .wb_rd_i       (wb_rd),
            .wb_we_i       (wb_we),
            .sel_o         (op_sel[g])
        );
    end

    assign fwd_ex_a = op_sel[0];
    assign fwd_ex_b = op_sel[1];
    assign fwd_id_a = op_sel[2];
    assign fwd_id_b = op_sel[3];

    hz_stall_detect #(
        .REG_W   (REG_W),
        .NUM_SRC (NUM_SRC)
    ) u_detect (
        .id_src_i       (id_src),
        .id_use_i       ({id_use_b, id_use_a}),
        .id_is_branch_i (id_is_branch),
        .ex_rd_i        (ex_rd),
        .ex_we_i        (ex_we),
        .ex_is_load_i   (ex_is_load),
        .mem_rd_i       (mem_rd),
        .mem_we_i       (mem_we),
        .mem_is_load_i  (mem_is_load),
        .load_use_o     (load_use),
        .br_wait_o      (br_wait)
    );

    hz_ctrl u_ctrl (
        .load_use_i  (load_use),
        .br_wait_i   (br_wait),
        .is_branch_i (id_is_branch),
        .br_taken_i  (id_br_taken),
        .hold_o      (front_hold),
        .bubble_o    (idex_bubble),
        .flush_o     (ifid_flush)
    );

    always_comb begin
        a_r11_flush_needs_branch: assert (!ifid_flush || id_is_branch);
        if (fwd_ex_a == 2'b01) begin
            a_r3_mem_fwd_needs_we: assert (mem_we);
        end
        if (fwd_id_a == 2'b01) begin
            a_r6_id_fwd_not_load: assert (!mem_is_load);
        end
        if (ex_is_load && ex_we && id_use_a && (ex_rd == id_rs_a)) begin
            a_r4_load_use_holds: assert (front_hold && !ifid_flush);
        end
    end

endmodule

// File: tb/hz_unit_tb.sv
module hz_unit_tb;

    typedef struct {
        string      tag;
        logic [1:0] ea;
        logic [1:0] eb;
        logic [1:0] ia;
        logic [1:0] ib;
        logic       hold;
        logic       bub;
        logic       flush;
    } exp_t;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic [3:0] id_rs_a, id_rs_b, ex_rs_a, ex_rs_b, ex_rd, mem_rd, wb_rd;
    logic id_use_a, id_use_b, id_is_branch, id_br_taken;
    logic ex_we, ex_is_load, mem_we, mem_is_load, wb_we;
    logic [1:0] fwd_ex_a, fwd_ex_b, fwd_id_a, fwd_id_b;
    logic front_hold, idex_bubble, ifid_flush;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    exp_t q[$];

    hz_unit u_dut (
        .id_rs_a(id_rs_a), .id_rs_b(id_rs_b), .id_use_a(id_use_a), .id_use_b(id_use_b),
        .id_is_branch(id_is_branch), .id_br_taken(id_br_taken),
        .ex_rs_a(ex_rs_a), .ex_rs_b(ex_rs_b), .ex_rd(ex_rd), .ex_we(ex_we),
        .ex_is_load(ex_is_load), .mem_rd(mem_rd), .mem_we(mem_we),
        .mem_is_load(mem_is_load), .wb_rd(wb_rd), .wb_we(wb_we),
        .fwd_ex_a(fwd_ex_a), .fwd_ex_b(fwd_ex_b), .fwd_id_a(fwd_id_a),
        .fwd_id_b(fwd_id_b), .front_hold(front_hold), .idex_bubble(idex_bubble),
        .ifid_flush(ifid_flush)
    );

    task automatic idle();
        id_rs_a = 4'd10; id_rs_b = 4'd11; id_use_a = 1'b0; id_use_b = 1'b0;
        id_is_branch = 1'b0; id_br_taken = 1'b0;
        ex_rs_a = 4'd12; ex_rs_b = 4'd13; ex_rd = 4'd0; ex_we = 1'b0; ex_is_load = 1'b0;
        mem_rd = 4'd0; mem_we = 1'b0; mem_is_load = 1'b0;
        wb_rd = 4'd0; wb_we = 1'b0;
    endtask

    task automatic expect_out(string tag, logic [1:0] ea, logic [1:0] eb,
                              logic [1:0] ia, logic [1:0] ib,
                              logic hold, logic bub, logic flush);
        exp_t e;
        e.tag = tag; e.ea = ea; e.eb = eb; e.ia = ia; e.ib = ib;
        e.hold = hold; e.bub = bub; e.flush = flush;
        q.push_back(e);
        @(posedge clk);
        idle();
    endtask

    always @(negedge clk) begin
        if (q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            checks++;
            if ({fwd_ex_a, fwd_ex_b, fwd_id_a, fwd_id_b, front_hold, idex_bubble, ifid_flush}
                !== {e.ea, e.eb, e.ia, e.ib, e.hold, e.bub, e.flush}) begin
                errors++;
                $display("FAIL %s actual ea=%b eb=%b ia=%b ib=%b h=%b b=%b f=%b expected ea=%b eb=%b ia=%b ib=%b h=%b b=%b f=%b",
                         e.tag, fwd_ex_a, fwd_ex_b, fwd_id_a, fwd_id_b, front_hold,
                         idex_bubble, ifid_flush, e.ea, e.eb, e.ia, e.ib, e.hold, e.bub, e.flush);
            end
        end
    end

    initial begin
        int cyc = 0;
        while (!done && cyc < 5000) begin
            @(posedge clk);
            cyc++;
        end
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        idle();
        @(posedge clk);
        // R3: all enables low after reset state
        expect_out("R3 idle", 2'b00, 2'b00, 2'b00, 2'b00, 0, 0, 0);
        mem_rd = 4'd3; mem_we = 1'b1; ex_rs_a = 4'd3;
        expect_out("R1 ex_a from memory", 2'b01, 2'b00, 2'b00, 2'b00, 0, 0, 0);
        wb_rd = 4'd5; wb_we = 1'b1; ex_rs_b = 4'd5;
        expect_out("R1 ex_b from write-back", 2'b00, 2'b10, 2'b00, 2'b00, 0, 0, 0);
        mem_rd = 4'd7; mem_we = 1'b1; wb_rd = 4'd7; wb_we = 1'b1; ex_rs_a = 4'd7; ex_rs_b = 4'd7;
        expect_out("R2 memory over write-back", 2'b01, 2'b01, 2'b00, 2'b00, 0, 0, 0);
        mem_rd = 4'd7; mem_we = 1'b0; wb_rd = 4'd7; wb_we = 1'b1; ex_rs_a = 4'd7;
        expect_out("R3 disabled memory stage", 2'b10, 2'b00, 2'b00, 2'b00, 0, 0, 0);
        ex_rs_b = 4'd4; wb_rd = 4'd4; wb_we = 1'b0;
        expect_out("R3 disabled write-back", 2'b00, 2'b00, 2'b00, 2'b00, 0, 0, 0);
        ex_rd = 4'd2; ex_we = 1'b1; ex_is_load = 1'b1; id_rs_a = 4'd2; id_use_a = 1'b1;
        expect_out("R4 load-use stall", 2'b00, 2'b00, 2'b00, 2'b00, 1, 1, 0);
        ex_rd = 4'd2; ex_we = 1'b1; ex_is_load = 1'b1; id_rs_b = 4'd2; id_use_b = 1'b0;
        id_rs_a = 4'd9; id_use_a = 1'b1;
        expect_out("R5 unused source", 2'b00, 2'b00, 2'b00, 2'b00, 0, 0, 0);
        ex_rd = 4'd5; ex_we = 1'b1; id_rs_a = 4'd5; id_use_a = 1'b1;
        expect_out("R5 alu producer non-branch", 2'b00, 2'b00, 2'b00, 2'b00, 0, 0, 0);
        // R7 and R10: taken branch waits on an execute ALU result
        ex_rd = 4'd4; ex_we = 1'b1; id_rs_b = 4'd4; id_use_b = 1'b1;
        id_is_branch = 1'b1; id_br_taken = 1'b1;
        expect_out("R7 R10 branch on execute", 2'b00, 2'b00, 2'b00, 2'b00, 1, 1, 0);
        mem_rd = 4'd6; mem_we = 1'b1; mem_is_load = 1'b1; id_rs_a = 4'd6; id_use_a = 1'b1;
        id_is_branch = 1'b1;
        expect_out("R8 R6 branch on memory load", 2'b00, 2'b00, 2'b00, 2'b00, 1, 1, 0);
        mem_rd = 4'd6; mem_we = 1'b1; id_rs_a = 4'd6; id_use_a = 1'b1;
        id_is_branch = 1'b1; id_br_taken = 1'b1;
        expect_out("R6 R9 taken branch fwd memory", 2'b00, 2'b00, 2'b01, 2'b00, 0, 0, 1);
        wb_rd = 4'd8; wb_we = 1'b1; id_rs_b = 4'd8; id_use_b = 1'b1; id_is_branch = 1'b1;
        expect_out("R6 R9 not-taken branch fwd wb", 2'b00, 2'b00, 2'b00, 2'b10, 0, 0, 0);
        id_br_taken = 1'b1;
        expect_out("R11 taken without branch", 2'b00, 2'b00, 2'b00, 2'b00, 0, 0, 0);
        ex_rd = 4'd3; ex_we = 1'b1; ex_is_load = 1'b1; id_rs_a = 4'd3; id_use_a = 1'b1;
        id_is_branch = 1'b1; id_br_taken = 1'b1;
        expect_out("R10 R4 taken branch behind load", 2'b00, 2'b00, 2'b00, 2'b00, 1, 1, 0);
        id_is_branch = 1'b1; id_br_taken = 1'b1; id_rs_a = 4'd3; id_use_a = 1'b1;
        expect_out("R9 flush after producer left", 2'b00, 2'b00, 2'b00, 2'b00, 0, 0, 1);
        mem_rd = 4'd9; mem_we = 1'b1; wb_rd = 4'd9; wb_we = 1'b1; id_rs_a = 4'd9;
        expect_out("R2 R6 decode priority", 2'b00, 2'b00, 2'b01, 2'b00, 0, 0, 0);
        mem_rd = 4'd9; mem_we = 1'b1; mem_is_load = 1'b1; wb_rd = 4'd9; wb_we = 1'b1;
        id_rs_a = 4'd9; ex_rs_a = 4'd9;
        expect_out("R6 R1 memory load split", 2'b01, 2'b00, 2'b00, 2'b00, 0, 0, 0);
        @(posedge clk);
        @(posedge clk);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule